// File: doc/BRIEF.md
# MSI Snooping Cache Controller

This block is the coherence engine of one private, direct-mapped data cache attached to a shared snooping bus. Every line carries one of three protocol states, Invalid, Shared or Modified, and the controller moves lines between them under two sources of events. The first source is load and store requests from the local processor. The second is miss transactions from other caches, seen on the snoop port. Local misses, upgrades and evictions of dirty lines become bus transactions: a read miss, a write miss (which also invalidates the line elsewhere) or a write-back. When a snooped miss hits a dirty local line, the block supplies the data on a flush output in that same cycle.

The processor port uses valid/ready. The processor raises `cpu_req_valid` and holds the write flag, address and write data steady until it sees `cpu_req_ready` high at a clock edge. The handshake cycle is also the response cycle: `cpu_rsp_rdata` is valid for reads in exactly that cycle, and the response side has no back-pressure. On the bus side, `bus_req` is held with a stable command, address and data until the external arbiter grants. The transaction takes place in the cycle in which `bus_req` and `bus_gnt` are both high and `snp_valid` is low, and read data is taken from `bus_rdata` in that cycle. Snooped transactions arrive one per cycle on `snp_valid`, and each one takes effect in its own cycle.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first access to any address misses. While no request or snoop is present, `bus_req`, `snp_flush` and `cpu_req_ready` are low.
- R2: A load that misses on an Invalid or Shared line issues one read miss (`bus_cmd`=01) to the load address. It completes in the grant cycle with the bus data and leaves the line Shared.
- R3: A store to a line that is Invalid, Shared or holding another address (and not dirty) issues one write miss (`bus_cmd`=10) to the store address. It is not acknowledged before the grant cycle, and it leaves the line Modified with the store data.
- R4: A load that hits, or a store that hits a Modified line, completes in the cycle it is presented, with no bus request and no change of line state. A load hit returns the line data.
- R5: A load to a line that is Modified with another tag first writes the old block back (`bus_cmd`=11, address = old tag concatenated with the index, old data). It then issues a read miss and ends Shared.
- R6: A store to a line that is Modified with another tag writes the old block back, issues a write miss and ends Modified with the new data.
- R7: A snooped read miss (`snp_write`=0) that matches a Modified line raises `snp_flush` in the same cycle with the line data, and the line becomes Shared. A match on a Shared line, or no match, raises no flush.
- R8: A snooped write miss (`snp_write`=1) that matches a line makes it Invalid, and a Modified line flushes its data in that cycle first.
- R9: While a bus request waits for a grant, `bus_cmd` and `bus_addr` stay unchanged and `cpu_req_ready` stays low.
- R10: In a cycle with `snp_valid` high, the block accepts no processor request and performs no bus transaction, even if granted.
- R11: The line index is the low log2(LINES) address bits and the tag is all remaining upper bits. Two addresses with equal index and different tags evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted and answered this cycle |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | AW | Word address of the request |
| cpu_req_wdata | input | DW | Store data |
| cpu_rsp_rdata | output | DW | Load data, valid in the handshake cycle |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus granted this cycle |
| bus_cmd | output | 2 | 00 none, 01 read miss, 10 write miss, 11 write-back |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Write-back data |
| bus_rdata | input | DW | Memory data for a miss, sampled in the grant cycle |
| snp_valid | input | 1 | Snooped miss from another cache |
| snp_write | input | 1 | 1 = write miss/invalidate, 0 = read miss |
| snp_addr | input | AW | Snooped address |
| snp_flush | output | 1 | Local dirty copy supplied this cycle |
| snp_flush_data | output | DW | Supplied block data |

## Verification
The hardest situation to reach is a snoop that lands while the controller is in the middle of its own multi-step transaction. Examples are a snoop arriving while a write-back waits for the bus, or in the same cycle as a grant that must then be ignored. The stimulus reaches these cases by injecting snoops to a neighbouring line in the first cycles of a processor request and forcing the grant high in those cycles. It also delays grants at random, so that requests wait at both the write-back step and the miss step. A small pool of tags per index keeps evictions of dirty lines frequent, and randomly mixed snoops keep moving lines between all three states.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_MOD = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE   = 2'd0,
    BC_RDMISS = 2'd1,
    BC_WRMISS = 2'd2,
    BC_WBACK  = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    CT_IDLE  = 2'd0,
    CT_WBACK = 2'd1,
    CT_FETCH = 2'd2
  } ctl_st_e;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int LINES = 4,
  parameter int TW    = 6,
  parameter int DW    = 32,
  localparam int IW   = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] lk_idx,
  output line_st_e      lk_st,
  output logic [TW-1:0] lk_tag,
  output logic [DW-1:0] lk_data,
  input  logic          snp_valid,
  input  logic          snp_wr,
  input  logic [IW-1:0] snp_idx,
  input  logic [TW-1:0] snp_tag,
  output logic          snp_flush,
  output logic [DW-1:0] snp_data,
  input  logic          upd_en,
  input  logic [IW-1:0] upd_idx,
  input  line_st_e      upd_st,
  input  logic [TW-1:0] upd_tag,
  input  logic [DW-1:0] upd_data
);
  line_st_e      st_a  [LINES];
  logic [TW-1:0] tag_a [LINES];
  logic [DW-1:0] dat_a [LINES];
  logic          s_hit;

  // snoop tag match against the addressed line
  assign s_hit     = snp_valid && (st_a[snp_idx] != LN_INV) && (tag_a[snp_idx] == snp_tag);
  assign snp_flush = s_hit && (st_a[snp_idx] == LN_MOD);
  assign snp_data  = dat_a[snp_idx];

  assign lk_st   = st_a[lk_idx];
  assign lk_tag  = tag_a[lk_idx];
  assign lk_data = dat_a[lk_idx];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_e      st_r;
    logic [TW-1:0] tag_r;
    logic [DW-1:0] dat_r;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_r  <= LN_INV;
        tag_r <= '0;
        dat_r <= '0;
      end else if (s_hit && (snp_idx == IW'(g))) begin
        // snooped events win over any local update of the same line
        if (snp_wr)               st_r <= LN_INV;
        else if (st_r == LN_MOD)  st_r <= LN_SHR;
      end else if (upd_en && (upd_idx == IW'(g))) begin
        st_r  <= upd_st;
        tag_r <= upd_tag;
        dat_r <= upd_data;
      end
    end
    assign st_a[g]  = st_r;
    assign tag_a[g] = tag_r;
    assign dat_a[g] = dat_r;
  end

  // ---- checks ----
  logic [IW-1:0] snp_idx_q;
  always_ff @(posedge clk) snp_idx_q <= snp_idx;

  // R8: a matching snooped write miss leaves the line Invalid
  p_snp_wr_kills_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_wr && s_hit) |=> (st_a[snp_idx_q] == LN_INV));

  // R7: a snooped read miss demotes a dirty line to Shared
  p_snp_rd_demotes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !snp_wr && snp_flush) |=> (st_a[snp_idx_q] == LN_SHR));

  // R7: a Shared line keeps its state under a snooped read miss
  p_snp_rd_keeps_shr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !snp_wr && st_a[snp_idx] == LN_SHR) |=> (st_a[snp_idx_q] == LN_SHR));
endmodule

// File: rtl/msi_req_fsm.sv
module msi_req_fsm
  import msi_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int LINES = 4,
  localparam int IW   = $clog2(LINES),
  localparam int TW   = AW - IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req_valid,
  output logic          cpu_req_ready,
  input  logic          cpu_req_write,
  input  logic [AW-1:0] cpu_req_addr,
  input  logic [DW-1:0] cpu_req_wdata,
  output logic [DW-1:0] cpu_rsp_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output bus_cmd_e      bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          snp_valid,
  input  line_st_e      lk_st,
  input  logic [TW-1:0] lk_tag,
  input  logic [DW-1:0] lk_data,
  output logic          upd_en,
  output line_st_e      upd_st,
  output logic [TW-1:0] upd_tag,
  output logic [DW-1:0] upd_data
);
  ctl_st_e       cur_q, nxt;
  logic [IW-1:0] idx;
  logic [TW-1:0] tag;
  logic          hit, go;

  assign idx = cpu_req_addr[IW-1:0];
  assign tag = cpu_req_addr[AW-1:IW];
  assign hit = (lk_st != LN_INV) && (lk_tag == tag);
  // a grant counts only in a cycle free of snoop traffic
  assign go  = bus_req && bus_gnt && !snp_valid;

  always_comb begin
    nxt           = cur_q;
    cpu_req_ready = 1'b0;
    cpu_rsp_rdata = lk_data;
    bus_req       = 1'b0;
    bus_cmd       = BC_NONE;
    bus_addr      = '0;
    bus_wdata     = '0;
    upd_en        = 1'b0;
    upd_st        = lk_st;
    upd_tag       = tag;
    upd_data      = cpu_req_wdata;
    unique case (cur_q)
      CT_IDLE: begin
        if (cpu_req_valid && !snp_valid) begin
          if (hit && !cpu_req_write) begin
            cpu_req_ready = 1'b1;
          end else if (hit && lk_st == LN_MOD) begin
            cpu_req_ready = 1'b1;
            upd_en        = 1'b1;
            upd_st        = LN_MOD;
          end else if (!hit && lk_st == LN_MOD) begin
            nxt = CT_WBACK;
          end else begin
            nxt = CT_FETCH;
          end
        end
      end
      CT_WBACK: begin
        if (lk_st != LN_MOD) begin
          // a snoop already took the dirty copy away
          nxt = CT_FETCH;
        end else begin
          bus_req   = 1'b1;
          bus_cmd   = BC_WBACK;
          bus_addr  = {lk_tag, idx};
          bus_wdata = lk_data;
          if (go) nxt = CT_FETCH;
        end
      end
      CT_FETCH: begin
        bus_req  = 1'b1;
        bus_cmd  = cpu_req_write ? BC_WRMISS : BC_RDMISS;
        bus_addr = cpu_req_addr;
        if (go) begin
          cpu_req_ready = 1'b1;
          cpu_rsp_rdata = bus_rdata;
          upd_en        = 1'b1;
          upd_st        = cpu_req_write ? LN_MOD : LN_SHR;
          upd_data      = cpu_req_write ? cpu_req_wdata : bus_rdata;
          nxt           = CT_IDLE;
        end
      end
      default: nxt = CT_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cur_q <= CT_IDLE;
    else        cur_q <= nxt;
  end

  // ---- checks ----
  // R5: a completed write-back is followed by a miss request
  p_wb_then_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && !snp_valid && bus_cmd == BC_WBACK)
      |=> (bus_req && (bus_cmd == BC_RDMISS || bus_cmd == BC_WRMISS)));

  // R9: a waiting request keeps command and address
  p_hold_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && !snp_valid && cpu_req_valid)
      |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

  // R10: snoop cycles block local progress
  p_snoop_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> (!cpu_req_ready && !upd_en));

  // R3: a store that needed the bus is acknowledged only with a grant
  p_store_waits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_ready && cpu_req_write && bus_req) |-> bus_gnt);
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int LINES = 4,
  localparam int IW   = $clog2(LINES),
  localparam int TW   = AW - IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req_valid,
  output logic          cpu_req_ready,
  input  logic          cpu_req_write,
  input  logic [AW-1:0] cpu_req_addr,
  input  logic [DW-1:0] cpu_req_wdata,
  output logic [DW-1:0] cpu_rsp_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          snp_valid,
  input  logic          snp_write,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_flush,
  output logic [DW-1:0] snp_flush_data
);
  line_st_e      lk_st, upd_st;
  logic [TW-1:0] lk_tag, upd_tag;
  logic [DW-1:0] lk_data, upd_data;
  logic          upd_en;
  bus_cmd_e      cmd_e;

  assign bus_cmd = cmd_e;

  msi_req_fsm #(.AW(AW), .DW(DW), .LINES(LINES)) u_fsm (
    .clk, .rst_n,
    .cpu_req_valid, .cpu_req_ready, .cpu_req_write, .cpu_req_addr,
    .cpu_req_wdata, .cpu_rsp_rdata,
    .bus_req, .bus_gnt, .bus_cmd(cmd_e), .bus_addr, .bus_wdata, .bus_rdata,
    .snp_valid,
    .lk_st, .lk_tag, .lk_data,
    .upd_en, .upd_st, .upd_tag, .upd_data
  );

  msi_line_store #(.LINES(LINES), .TW(TW), .DW(DW)) u_store (
    .clk, .rst_n,
    .lk_idx   (cpu_req_addr[IW-1:0]),
    .lk_st, .lk_tag, .lk_data,
    .snp_valid,
    .snp_wr   (snp_write),
    .snp_idx  (snp_addr[IW-1:0]),
    .snp_tag  (snp_addr[AW-1:IW]),
    .snp_flush,
    .snp_data (snp_flush_data),
    .upd_en,
    .upd_idx  (cpu_req_addr[IW-1:0]),
    .upd_st, .upd_tag, .upd_data
  );
endmodule

// File: tb/msi_snoop_ctrl_tb_top.sv
`timescale 1ns/100ps
module msi_snoop_ctrl_tb_top;
  localparam int AW = 8, DW = 32, LINES = 4, IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic          cpu_req_ready;
  logic [DW-1:0] cpu_rsp_rdata;
  logic          bus_req, bus_gnt = 1'b0;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata = '0;
  logic          snp_valid = 1'b0, snp_write = 1'b0;
  logic [AW-1:0] snp_addr = '0;
  logic          snp_flush;
  logic [DW-1:0] snp_flush_data;

  always #2 clk = ~clk;

  msi_snoop_ctrl #(.AW(AW), .DW(DW), .LINES(LINES)) dut_i (.*);

  int errs = 0, checks = 0;
  int mst [LINES];
  logic [AW-IW-1:0] mtag [LINES];
  logic [DW-1:0] mdat [LINES];
  logic [DW-1:0] gold [256];
  logic [DW-1:0] mem  [256];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int t, input int i);
    return AW'((t << IW) | i);
  endfunction

  // effect of the snoop currently driven; call at the sample point
  task automatic snoop_effect();
    int i = int'(snp_addr[IW-1:0]);
    logic [AW-IW-1:0] t = snp_addr[AW-1:IW];
    bit h = (mst[i] != 0) && (mtag[i] == t);
    bit ef = h && (mst[i] == 2);
    string rq = snp_write ? "R8" : "R7";
    logic [DW-1:0] nv;
    chk(snp_flush == ef, rq, "snoop flush", 32'(snp_flush), 32'(ef));
    if (ef) begin
      chk(snp_flush_data == mdat[i], rq, "flush data", snp_flush_data, mdat[i]);
      mem[snp_addr] = mdat[i];
    end
    if (h) mst[i] = snp_write ? 0 : ((mst[i] == 2) ? 1 : mst[i]);
    if (snp_write) begin
      nv = $urandom;
      gold[snp_addr] = nv;
      mem[snp_addr] = nv;
    end
  endtask

  task automatic do_snoop(input bit w, input logic [AW-1:0] a);
    snp_valid = 1'b1; snp_write = w; snp_addr = a;
    #1;
    snoop_effect();
    @(posedge clk); @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic cpu_op(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit inj);
    int i = int'(a[IW-1:0]);
    logic [AW-IW-1:0] t = a[AW-1:IW];
    bit h = (mst[i] != 0) && (mtag[i] == t);
    logic [1:0] ec [2];
    logic [AW-1:0] ea [2];
    logic [DW-1:0] ed [2];
    int en = 0, got = 0, cyc = 0, inj_cyc = int'($urandom % 2);
    bit done = 0;
    string rq;
    if (!w && h)                 rq = "R4";
    else if (w && h && mst[i]==2) rq = "R4";
    else if (!h && mst[i] == 2) begin
      rq = w ? "R6" : "R5";
      ec[0] = 2'b11; ea[0] = mk(int'(mtag[i]), i); ed[0] = mdat[i]; en = 1;
    end else rq = w ? "R3" : "R2";
    if (!(h && (!w || mst[i] == 2))) begin
      ec[en] = w ? 2'b10 : 2'b01; ea[en] = a; ed[en] = '0; en++;
    end
    cpu_req_valid = 1'b1; cpu_req_write = w; cpu_req_addr = a; cpu_req_wdata = d;
    while (!done && cyc < 40) begin
      snp_valid = 1'b0;
      if (inj && cyc == inj_cyc) begin
        snp_valid = 1'b1; snp_write = 1'($urandom);
        snp_addr = mk(int'($urandom % 3), (i + 1) % LINES);
      end
      #0.5;
      bus_gnt = snp_valid ? bus_req : (bus_req && ($urandom % 3 != 0));
      bus_rdata = mem[bus_addr];
      #0.5;
      if (snp_valid) begin
        chk(!cpu_req_ready, "R10", "ready during snoop", 32'(cpu_req_ready), 0);
        snoop_effect();
      end else if (bus_gnt) begin
        if (got < en) begin
          chk(bus_cmd == ec[got], rq, "bus cmd", 32'(bus_cmd), 32'(ec[got]));
          chk(bus_addr == ea[got], (ec[got] == 2'b11) ? "R11" : rq, "bus addr",
              32'(bus_addr), 32'(ea[got]));
          if (ec[got] == 2'b11)
            chk(bus_wdata == ed[got], rq, "writeback data", bus_wdata, ed[got]);
        end else chk(0, rq, "unexpected bus transaction", 32'(bus_cmd), 0);
        if (bus_cmd == 2'b11) mem[bus_addr] = bus_wdata;
        got++;
      end else if (bus_req) begin
        chk(!cpu_req_ready, "R9", "ready while waiting", 32'(cpu_req_ready), 0);
      end
      if (cpu_req_ready && !snp_valid) begin
        done = 1;
        chk(got == en, rq, "transaction count", 32'(got), 32'(en));
        if (!w) chk(cpu_rsp_rdata == gold[a], rq, "load data", cpu_rsp_rdata, gold[a]);
      end
      @(posedge clk); @(negedge clk);
      cyc++;
    end
    cpu_req_valid = 1'b0; bus_gnt = 1'b0; snp_valid = 1'b0;
    if (!done) chk(0, rq, "request never completed", 0, 1);
    mtag[i] = t;
    if (w) begin gold[a] = d; mdat[i] = d; mst[i] = 2; end
    else begin mdat[i] = gold[a]; if (!(h)) mst[i] = 1; end
  endtask

  initial begin
    #400000;
    errs++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 256; k++) begin mem[k] = 32'(k * 7 + 3); gold[k] = mem[k]; end
    for (int k = 0; k < LINES; k++) begin mst[k] = 0; mtag[k] = '0; mdat[k] = '0; end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!bus_req, "R1", "bus_req after reset", 32'(bus_req), 0);
    chk(!snp_flush, "R1", "flush after reset", 32'(snp_flush), 0);
    chk(!cpu_req_ready, "R1", "ready idle", 32'(cpu_req_ready), 0);
    @(negedge clk);
    // R1/R2: cold misses on every line
    for (int k = 0; k < LINES; k++) cpu_op(0, mk(0, k), '0, 0);
    cpu_op(0, mk(0, 1), '0, 0);            // R4 read hit
    cpu_op(1, mk(0, 1), 32'hA1, 0);         // R3 upgrade from Shared
    cpu_op(1, mk(0, 1), 32'hA2, 0);         // R4 write hit Modified
    cpu_op(0, mk(2, 1), '0, 0);            // R5 dirty eviction by load
    cpu_op(1, mk(1, 2), 32'hB1, 0);         // R3 write miss
    cpu_op(1, mk(3, 2), 32'hB2, 0);         // R6 dirty eviction by store
    do_snoop(0, mk(3, 2));                 // R7 flush, to Shared
    do_snoop(0, mk(3, 2));                 // R7 Shared: no flush
    cpu_op(0, mk(3, 2), '0, 0);            // still a hit (R4)
    cpu_op(1, mk(0, 3), 32'hC1, 0);
    do_snoop(1, mk(0, 3));                 // R8 dirty invalidate
    cpu_op(0, mk(0, 3), '0, 0);            // R2 miss fetches new value
    do_snoop(1, mk(0, 3));                 // R8 Shared invalidate
    cpu_op(0, mk(0, 3), '0, 0);
    cpu_op(1, mk(1, 0), 32'hD1, 1);         // R10 snoop during request
    cpu_op(0, mk(2, 0), '0, 1);
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a = mk(int'($urandom % 3), int'($urandom % LINES));
      if ($urandom % 4 == 0) do_snoop(1'($urandom), a);
      else cpu_op(1'($urandom), a, $urandom, ($urandom % 8 == 0));
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule